// File: doc/BRIEF.md
# Serial Receive Character Buffer with Interrupt Causes

This block sits between a serial deserializer and the software-visible side of a serial port. Each received character arrives with three error flags: break, parity and framing. The block queues them in order and shows the oldest one as a read word. That word carries a valid flag, so a reader can tell whether the buffer held anything. Software drains the buffer by pulsing a read strobe. It can keep reading while a separate not-empty status bit is set.

Three interrupt causes are produced. The first is a sticky overrun flag, set when a character arrives with no room for it. The second is a fill level strictly above a programmable threshold. The third is an inactivity timeout, counted in character times, that fires when data sits in the buffer below the threshold and nobody touches it. Each cause has its own mask bit, and the interrupt line is the OR of the unmasked causes. A reset control bit empties the buffer and is the only way to clear overrun.

The input is a valid/ready stream, but the deserializer cannot stall. `in_ready` only reports whether there is room. A character offered while `in_ready` is low is dropped and flags overrun. `char_tick` is a one-cycle pulse per character time from the baud logic.

Top module: `uart_rx_fifo_irq`

## Requirements
- R1: After `rst_n` is released, `irq_stat` is 0, `irq` is 0, `rd_word` is all zero and `in_ready` is 1.
- R2: Characters are read back in arrival order. `rd_word` shows the oldest entry with [7:0] data, [8] framing error, [9] parity error, [10] break and [11] valid = 1. A cycle with `rd_en` high removes that entry.
- R3: While the buffer is empty, `rd_word` is all zero (valid clear), and `rd_en` has no effect on the contents or order of later data.
- R4: `irq_stat` bit positions: [0] overrun, [1] above threshold, [2] timeout, [3] not empty. Each bit reflects a write or read by the following clock cycle.
- R5: `irq_stat[1]` is 1 exactly when the fill level is strictly greater than `thr_cfg`.
- R6: With DEPTH entries stored, `in_ready` is 0. A character offered then is discarded, the stored entries are unchanged, and `irq_stat[0]` becomes 1.
- R7: Overrun stays set through reads, writes and drains. It is cleared only by `fifo_rst`. `fifo_rst` also empties the buffer and clears the timeout, and it wins over a same-cycle write, which is then neither stored nor counted as overrun.
- R8: The timeout counter counts `char_tick` pulses while the buffer is non-empty. Any offered character or any read of a stored entry restarts it from zero. `irq_stat[2]` rises once the count reaches `tmo_cfg`. A `tmo_cfg` of 0 disables the timeout.
- R9: `irq_stat[2]` stays 0 while `irq_stat[1]` is 1.
- R10: `irq` is the OR of `irq_stat[i] & irq_mask[i]` for i = 0..2. The not-empty bit never drives `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Deserializer offers a character |
| in_ready | output | 1 | Room for one more character |
| in_data | input | DATA_W | Received character |
| in_brk | input | 1 | Break detected on this character |
| in_par_err | input | 1 | Parity error on this character |
| in_frm_err | input | 1 | Framing error on this character |
| char_tick | input | 1 | One pulse per character time |
| rd_en | input | 1 | Remove the displayed entry |
| rd_word | output | DATA_W+4 | Oldest entry with flags and valid bit |
| thr_cfg | input | $clog2(DEPTH)+1 | Fill threshold (strictly-greater compare) |
| tmo_cfg | input | CNT_W | Timeout in character times, 0 = off |
| irq_mask | input | 3 | Enables for overrun, threshold, timeout |
| fifo_rst | input | 1 | Empty buffer, clear overrun and timeout |
| irq_stat | output | 4 | Not empty, timeout, threshold, overrun |
| irq | output | 1 | OR of unmasked causes |

## Verification
A read or write pointer that moves wrongly shows up on `rd_word` at the very next read. It appears as a wrong character, a stale flag, or a valid bit that disagrees with the not-empty bit. A drop that still advances the write pointer corrupts the oldest entry, which only becomes visible when the buffer is drained. For that reason the full-buffer scenario reads every entry back.

Overrun and timeout state is observable one cycle after its cause, through `irq_stat` and through `irq` under each mask. A counter that fails to restart shows up as a timeout rising one tick early.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int unsigned ST_OVR   = 0;
  localparam int unsigned ST_THR   = 1;
  localparam int unsigned ST_TMO   = 2;
  localparam int unsigned ST_NE    = 3;
  localparam int unsigned N_CAUSE  = 3;
  localparam int unsigned N_STAT   = 4;
  localparam int unsigned N_FLAG   = 3;

  typedef struct packed {
    logic brk;
    logic par;
    logic frm;
  } rx_flags_t;
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
  parameter int unsigned EW    = 11,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [EW-1:0] din,
  output logic [EW-1:0] dout,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty,
  output logic          pop_ok
);
  logic [EW-1:0] mem [DEPTH];
  logic [AW:0]   wr_ptr;
  logic [AW:0]   rd_ptr;
  logic          push_ok;

  assign level   = wr_ptr - rd_ptr;
  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign push_ok = push && !full && !clr;
  assign pop_ok  = pop && !empty && !clr;
  assign dout    = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr[AW-1:0]] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/rxf_timeout.sv
module rxf_timeout #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             restart,
  input  logic             active,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr || restart || !active) begin
      cnt <= '0;
    end else if (tick && (cnt < limit)) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign expired = (limit != '0) && (cnt >= limit);
endmodule

// File: rtl/rxf_irq.sv
module rxf_irq
  import rxf_pkg::*;
#(
  parameter int unsigned LW = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               drop,
  input  logic [LW-1:0]      level,
  input  logic [LW-1:0]      thr_cfg,
  input  logic               expired,
  input  logic [N_CAUSE-1:0] mask,
  output logic [N_STAT-1:0]  stat,
  output logic               irq
);
  logic               ovr_q;
  logic               above;
  logic [N_CAUSE-1:0] masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ovr_q <= 1'b0;
    else if (clr)  ovr_q <= 1'b0;
    else if (drop) ovr_q <= 1'b1;
  end

  assign above = (level > thr_cfg);

  always_comb begin
    stat         = '0;
    stat[ST_OVR] = ovr_q;
    stat[ST_THR] = above;
    stat[ST_TMO] = expired && !above && (level != '0);
    stat[ST_NE]  = (level != '0);
  end

  for (genvar i = 0; i < N_CAUSE; i++) begin : g_mask
    assign masked[i] = stat[i] & mask[i];
  end

  assign irq = |masked;
endmodule

// File: rtl/uart_rx_fifo_irq.sv
module uart_rx_fifo_irq
  import rxf_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned CNT_W  = 8,
  localparam int unsigned LW    = $clog2(DEPTH) + 1,
  localparam int unsigned EW    = DATA_W + N_FLAG,
  localparam int unsigned RW    = EW + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [DATA_W-1:0]  in_data,
  input  logic               in_brk,
  input  logic               in_par_err,
  input  logic               in_frm_err,
  input  logic               char_tick,
  input  logic               rd_en,
  output logic [RW-1:0]      rd_word,
  input  logic [LW-1:0]      thr_cfg,
  input  logic [CNT_W-1:0]   tmo_cfg,
  input  logic [N_CAUSE-1:0] irq_mask,
  input  logic               fifo_rst,
  output logic [N_STAT-1:0]  irq_stat,
  output logic               irq
);
  rx_flags_t     in_flags;
  logic [EW-1:0] wr_entry;
  logic [EW-1:0] head;
  logic [LW-1:0] fill_lvl;
  logic          is_full;
  logic          is_empty;
  logic          popped;
  logic          dropped;
  logic          tmo_hit;

  assign in_flags = '{brk: in_brk, par: in_par_err, frm: in_frm_err};
  assign wr_entry = {in_flags, in_data};
  assign in_ready = !is_full;
  assign dropped  = in_valid && is_full && !fifo_rst;

  rxf_store #(.EW(EW), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (fifo_rst),
    .push  (in_valid),
    .pop   (rd_en),
    .din   (wr_entry),
    .dout  (head),
    .level (fill_lvl),
    .full  (is_full),
    .empty (is_empty),
    .pop_ok(popped)
  );

  rxf_timeout #(.CNT_W(CNT_W)) u_tmo (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (fifo_rst),
    .restart(in_valid || popped),
    .active (!is_empty),
    .tick   (char_tick),
    .limit  (tmo_cfg),
    .expired(tmo_hit)
  );

  rxf_irq #(.LW(LW)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (fifo_rst),
    .drop   (dropped),
    .level  (fill_lvl),
    .thr_cfg(thr_cfg),
    .expired(tmo_hit),
    .mask   (irq_mask),
    .stat   (irq_stat),
    .irq    (irq)
  );

  assign rd_word = is_empty ? '0 : {1'b1, head};
endmodule

// File: rtl/rxf_chk.sv
module rxf_chk #(
  parameter int unsigned LW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          rd_en,
  input logic          fifo_rst,
  input logic [LW-1:0] thr_cfg,
  input logic [3:0]    irq_stat,
  input logic [LW-1:0] level
);
  // R7
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_stat[0] && !fifo_rst |=> irq_stat[0]);

  // R7
  rst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rst |=> (level == '0) && !irq_stat[0]);

  // R6
  drop_keeps_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_ready && !rd_en && !fifo_rst |=> (level == $past(level)) && irq_stat[0]);

  // R3
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !irq_stat[3] && !in_valid && !fifo_rst |=> level == '0);

  // R8
  tmo_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_stat[2] |-> irq_stat[3]);

  // R8
  restart_clears_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> !irq_stat[2]);

  // R5
  thr_rise_from_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_stat[1]) && $stable(thr_cfg) |-> $past(in_valid && in_ready));
endmodule

bind uart_rx_fifo_irq rxf_chk #(.LW(LW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_valid(in_valid),
  .in_ready(in_ready),
  .rd_en   (rd_en),
  .fifo_rst(fifo_rst),
  .thr_cfg (thr_cfg),
  .irq_stat(irq_stat),
  .level   (fill_lvl)
);

// File: tb/uart_rx_fifo_irq_tb.sv
module uart_rx_fifo_irq_tb;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        in_brk = 1'b0;
  logic        in_par_err = 1'b0;
  logic        in_frm_err = 1'b0;
  logic        char_tick = 1'b0;
  logic        rd_en = 1'b0;
  logic [11:0] rd_word;
  logic [4:0]  thr_cfg = 5'd8;
  logic [7:0]  tmo_cfg = 8'd1;
  logic [2:0]  irq_mask = 3'b000;
  logic        fifo_rst = 1'b0;
  logic [3:0]  irq_stat;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  uart_rx_fifo_irq u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_brk(in_brk), .in_par_err(in_par_err),
    .in_frm_err(in_frm_err), .char_tick(char_tick), .rd_en(rd_en),
    .rd_word(rd_word), .thr_cfg(thr_cfg), .tmo_cfg(tmo_cfg),
    .irq_mask(irq_mask), .fifo_rst(fifo_rst), .irq_stat(irq_stat), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] d, input logic b, input logic p, input logic f);
    in_valid = 1'b1; in_data = d; in_brk = b; in_par_err = p; in_frm_err = f;
    @(negedge clk);
    in_valid = 1'b0; in_brk = 1'b0; in_par_err = 1'b0; in_frm_err = 1'b0;
  endtask

  task automatic pop();
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic tick();
    char_tick = 1'b1;
    @(negedge clk);
    char_tick = 1'b0;
  endtask

  task automatic clear_fifo();
    fifo_rst = 1'b1;
    @(negedge clk);
    fifo_rst = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 irq_stat", 32'(irq_stat), 32'h0);
    check("R1 irq", 32'(irq), 32'h0);
    check("R1 rd_word", 32'(rd_word), 32'h0);
    check("R1 in_ready", 32'(in_ready), 32'h1);
  endtask

  task automatic t_order_flags();
    clear_fifo();
    push(8'hA5, 1'b0, 1'b0, 1'b1);
    check("R4 not-empty after one write", 32'(irq_stat), 32'h8);
    push(8'h3C, 1'b0, 1'b1, 1'b0);
    push(8'h00, 1'b1, 1'b0, 1'b0);
    check("R2 head framing", 32'(rd_word), 32'h9A5);
    pop();
    check("R2 head parity", 32'(rd_word), 32'hA3C);
    pop();
    check("R2 head break", 32'(rd_word), 32'hC00);
    pop();
    check("R2 drained word", 32'(rd_word), 32'h0);
    check("R4 not-empty cleared", 32'(irq_stat[3]), 32'h0);
  endtask

  task automatic t_empty_read();
    clear_fifo();
    pop();
    pop();
    check("R3 empty read word", 32'(rd_word), 32'h0);
    push(8'h77, 1'b0, 1'b0, 1'b0);
    push(8'h78, 1'b0, 1'b0, 1'b0);
    check("R3 first after empty reads", 32'(rd_word), 32'h877);
    pop();
    check("R3 second after empty reads", 32'(rd_word), 32'h878);
    pop();
  endtask

  task automatic t_threshold();
    clear_fifo();
    thr_cfg = 5'd8;
    for (int i = 0; i < 8; i++) push(8'(i), 1'b0, 1'b0, 1'b0);
    check("R5 level equal to threshold", 32'(irq_stat[1]), 32'h0);
    push(8'h08, 1'b0, 1'b0, 1'b0);
    check("R5 level above threshold", 32'(irq_stat[1]), 32'h1);
    pop();
    check("R5 back to threshold", 32'(irq_stat[1]), 32'h0);
    thr_cfg = 5'd0;
    #1;
    check("R5 threshold zero with data", 32'(irq_stat[1]), 32'h1);
    thr_cfg = 5'd8;
    clear_fifo();
  endtask

  task automatic t_overrun();
    clear_fifo();
    for (int i = 0; i < DEPTH; i++) push(8'h40 + 8'(i), 1'b0, 1'b0, 1'b0);
    check("R6 ready low when full", 32'(in_ready), 32'h0);
    check("R6 no overrun yet", 32'(irq_stat[0]), 32'h0);
    push(8'hEE, 1'b1, 1'b1, 1'b1);
    check("R6 overrun set", 32'(irq_stat[0]), 32'h1);
    for (int i = 0; i < DEPTH; i++) begin
      check("R6 stored entry intact", 32'(rd_word), 32'h800 + 32'h40 + 32'(i));
      pop();
    end
    check("R6 dropped char absent", 32'(rd_word), 32'h0);
    check("R7 overrun survives drain", 32'(irq_stat[0]), 32'h1);
    push(8'h11, 1'b0, 1'b0, 1'b0);
    check("R7 overrun survives write", 32'(irq_stat[0]), 32'h1);
    fifo_rst = 1'b1; in_valid = 1'b1; in_data = 8'h22;
    @(negedge clk);
    fifo_rst = 1'b0; in_valid = 1'b0;
    check("R7 reset clears status", 32'(irq_stat), 32'h0);
    check("R7 reset wins over write", 32'(rd_word), 32'h0);
  endtask

  task automatic t_timeout();
    clear_fifo();
    tmo_cfg = 8'd2;
    thr_cfg = 5'd8;
    tick();
    check("R8 no count while empty", 32'(irq_stat[2]), 32'h0);
    push(8'h01, 1'b0, 1'b0, 1'b0);
    tick();
    check("R8 one tick of two", 32'(irq_stat[2]), 32'h0);
    tick();
    check("R8 expired at limit", 32'(irq_stat[2]), 32'h1);
    push(8'h02, 1'b0, 1'b0, 1'b0);
    check("R8 write restarts", 32'(irq_stat[2]), 32'h0);
    tick();
    tick();
    check("R8 expired again", 32'(irq_stat[2]), 32'h1);
    pop();
    check("R8 read restarts", 32'(irq_stat[2]), 32'h0);
    tick();
    check("R8 one tick after read", 32'(irq_stat[2]), 32'h0);
    tick();
    check("R8 expired after read", 32'(irq_stat[2]), 32'h1);
    pop();
    check("R8 cleared when empty", 32'(irq_stat[2]), 32'h0);
    tmo_cfg = 8'd0;
    push(8'h03, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) tick();
    check("R8 disabled by zero", 32'(irq_stat[2]), 32'h0);
    clear_fifo();
    tmo_cfg = 8'd1;
    thr_cfg = 5'd0;
    push(8'h04, 1'b0, 1'b0, 1'b0);
    tick();
    tick();
    check("R9 threshold suppresses timeout", 32'(irq_stat[2:1]), 32'h1);
    thr_cfg = 5'd8;
    #1;
    check("R9 timeout after threshold lifted", 32'(irq_stat[2:1]), 32'h2);
    clear_fifo();
  endtask

  task automatic t_mask();
    clear_fifo();
    tmo_cfg = 8'd1;
    thr_cfg = 5'd8;
    push(8'h10, 1'b0, 1'b0, 1'b0);
    irq_mask = 3'b111;
    #1;
    check("R10 not-empty never drives irq", 32'(irq), 32'h0);
    tick();
    check("R10 timeout status", 32'(irq_stat), 32'hC);
    irq_mask = 3'b011;
    #1;
    check("R10 timeout masked", 32'(irq), 32'h0);
    irq_mask = 3'b100;
    #1;
    check("R10 timeout enabled", 32'(irq), 32'h1);
    for (int i = 0; i < 9; i++) push(8'h20 + 8'(i), 1'b0, 1'b0, 1'b0);
    check("R10 threshold status only", 32'(irq_stat), 32'hA);
    irq_mask = 3'b101;
    #1;
    check("R10 threshold masked", 32'(irq), 32'h0);
    irq_mask = 3'b010;
    #1;
    check("R10 threshold enabled", 32'(irq), 32'h1);
    irq_mask = 3'b000;
    clear_fifo();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_order_flags();
    t_empty_read();
    t_threshold();
    t_overrun();
    t_timeout();
    t_mask();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule